// File: doc/BRIEF.md
# Tagged-Word Synchronizing Memory Controller

This block sits in front of a small word-addressed store. Every word holds a data field and four state bits: a full/empty flag, a forwarding flag, a full/empty trap flag and a poison flag. A requester sends one operation at a time over a valid/ready channel. The operation says which full/empty condition the word must satisfy and which state the word is left in. Each attempt reads the word, evaluates it and writes the word back in the same cycle, so no other access can slip in between the check and the update.

An access whose condition does not hold is moved into a single waiting slot and tried again every `RETRY_GAP` cycles. The retry budget is `2**RETRY_W` attempts. While the slot waits, new requests are still accepted and served, so a producer can fill the word a consumer is waiting on. A word with its forwarding flag set sends the access on to the address held in its data field, at most once per request. A trap flag or the poison flag ends the access at once with a trap status. Every response carries the identifier of its request, so a waiting access may be answered after requests that came in later.

Top module: `fe_sync_mem_ctrl`

## Requirements
- R1: After reset every word is empty with its forwarding, trap and poison flags clear, `rsp_valid` is low and `req_ready` is high.
- R2: Operation code 6 (tag write) stores `req_wdata` and the tag bits `req_tag` (bit 3 poison, bit 2 full/empty trap, bit 1 forward, bit 0 full) and always answers status 0 (ok) with the word's previous data. It ignores every flag.
- R3: Operation code 0 (plain load) answers with the word's data. Code 1 (plain store) writes the data and returns 0. Neither code changes the full flag.
- R4: Code 2 (wait-full, leave full) on a full word answers with the data and leaves the word full.
- R5: Code 3 (wait-full, set empty) on a full word answers with the data and clears the full flag.
- R6: Code 4 (wait-empty, set full) on an empty word writes the data, sets the full flag and returns 0.
- R7: Code 5 (purge) clears the full flag without waiting and keeps the data.
- R8: An access whose full/empty condition fails is tried again every `RETRY_GAP` cycles. After `2**RETRY_W` failed attempts it answers status 1 (retry trap) with data 0 and leaves the word unchanged. That answer arrives `RETRY_GAP*(2**RETRY_W-1)` clock edges after the accepting edge.
- R9: While an access waits in the slot, other requests are accepted and answered. A fill by another request releases the waiter on its next attempt.
- R10: A word with the forward flag set sends a non-tag-write access on to the address in its low data bits. A second forward within one request answers status 3 (forward) with the second word's data, which is the pointer.
- R11: If the full/empty trap flag is set, codes 2, 3 and 4 answer status 2 (flag trap) with data 0 at once. Plain accesses to such a word are still forwarded.
- R12: On a poisoned word, every code except the tag write answers status 2 with data 0 and leaves the word unchanged.
- R13: Each response returns the `req_id` of its request. A request that would need the occupied slot is held off with `req_ready` low until the slot frees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | 4 | Tag bits for the tag write |
| req_id | input | ID_W | Request identifier |
| rsp_valid | output | 1 | Response pulse |
| rsp_id | output | ID_W | Identifier of the answered request |
| rsp_status | output | 2 | 0 ok, 1 retry trap, 2 flag trap, 3 forward |
| rsp_data | output | DATA_W | Read data or pointer |

## Verification
The bench builds the block with a 16-word, 16-bit store, a 3-bit retry counter (8 attempts) and a 2-cycle retry gap. With these values the full retry budget runs out in 14 edges, so the exact exhaustion time can be checked against the formula. A consumer can also be parked and then released by a producer well inside its budget, and a blocked second waiter is shown to be held off until the first one times out.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
package fe_pkg;
  typedef enum logic [2:0] {
    OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_RDFF = 3'd2, OP_RDFE = 3'd3,
    OP_WREF = 3'd4, OP_PURGE = 3'd5, OP_TAGSET = 3'd6
  } fe_op_e;

  typedef enum logic [1:0] {ST_OK = 2'd0, ST_RETRY = 2'd1, ST_TAG = 2'd2, ST_FWD = 2'd3} fe_st_e;

  typedef enum logic [1:0] {K_DONE = 2'd0, K_FWD = 2'd1, K_PARK = 2'd2} fe_kind_e;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_HOP = 2'd1, S_WAIT = 2'd2} fe_slot_e;

  typedef struct packed {
    logic poison;
    logic trap_fe;
    logic fwd;
    logic full;
  } fe_tag_t;
endpackage

// File: rtl/fe_tag_store.sv
`timescale 1ns/1ps
module fe_tag_store
  import fe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output fe_tag_t           rd_tag,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  fe_tag_t           wr_tag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] data_q [DEPTH];
  fe_tag_t           tag_w  [DEPTH];

  // Data field carries no reset; only the state bits do.
  always_ff @(posedge clk) begin
    if (we) data_q[wr_addr] <= wr_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    fe_tag_t tq;
    logic    hit;
    assign hit = we && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tq <= '0;
      else if (hit) tq <= wr_tag;
    end
    assign tag_w[g] = tq;
  end

  assign rd_data = data_q[rd_addr];
  assign rd_tag  = tag_w[rd_addr];
endmodule

// File: rtl/fe_access_eval.sv
`timescale 1ns/1ps
module fe_access_eval
  import fe_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int RETRY_W = 10
) (
  input  fe_op_e             op,
  input  logic [DATA_W-1:0]  wdata,
  input  fe_tag_t            tag_in,
  input  logic [DATA_W-1:0]  rd_data,
  input  fe_tag_t            rd_tag,
  input  logic               hopped,
  input  logic [RETRY_W-1:0] cnt,
  output fe_kind_e           kind,
  output fe_st_e             status,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               we,
  output logic [DATA_W-1:0]  wr_data,
  output fe_tag_t            wr_tag,
  output logic [ADDR_W-1:0]  fwd_addr
);
  logic sync_op;
  logic fail;

  assign sync_op  = (op == OP_RDFF) || (op == OP_RDFE) || (op == OP_WREF);
  assign fwd_addr = rd_data[ADDR_W-1:0];

  always_comb begin
    kind     = K_DONE;
    status   = ST_OK;
    rsp_data = '0;
    we       = 1'b0;
    wr_data  = rd_data;
    wr_tag   = rd_tag;
    fail     = 1'b0;
    if (op == OP_TAGSET) begin
      we       = 1'b1;
      wr_data  = wdata;
      wr_tag   = tag_in;
      rsp_data = rd_data;
    end else if (rd_tag.poison) begin
      status = ST_TAG;
    end else if (sync_op && rd_tag.trap_fe) begin
      status = ST_TAG;
    end else if (rd_tag.fwd) begin
      if (hopped) begin
        status   = ST_FWD;
        rsp_data = rd_data;
      end else begin
        kind = K_FWD;
      end
    end else begin
      case (op)
        OP_STORE: begin
          we      = 1'b1;
          wr_data = wdata;
        end
        OP_RDFF: begin
          if (rd_tag.full) rsp_data = rd_data;
          else             fail = 1'b1;
        end
        OP_RDFE: begin
          if (rd_tag.full) begin
            rsp_data    = rd_data;
            we          = 1'b1;
            wr_tag.full = 1'b0;
          end else begin
            fail = 1'b1;
          end
        end
        OP_WREF: begin
          if (!rd_tag.full) begin
            we          = 1'b1;
            wr_data     = wdata;
            wr_tag.full = 1'b1;
          end else begin
            fail = 1'b1;
          end
        end
        OP_PURGE: begin
          we          = 1'b1;
          wr_tag.full = 1'b0;
        end
        default: rsp_data = rd_data;
      endcase
      if (fail) begin
        if (cnt == {RETRY_W{1'b1}}) status = ST_RETRY;
        else                        kind   = K_PARK;
      end
    end
  end
endmodule

// File: rtl/fe_wait_slot.sv
`timescale 1ns/1ps
module fe_wait_slot
  import fe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int RETRY_W   = 10,
  parameter int RETRY_GAP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               att_valid,
  input  logic               att_from_slot,
  input  fe_kind_e           att_kind,
  input  fe_op_e             att_op,
  input  logic [ADDR_W-1:0]  att_addr,
  input  logic [ADDR_W-1:0]  fwd_addr,
  input  logic [DATA_W-1:0]  att_wdata,
  input  fe_tag_t            att_tag,
  input  logic [ID_W-1:0]    att_id,
  input  logic               att_hopped,
  input  logic [RETRY_W-1:0] att_cnt,
  output fe_slot_e           st,
  output logic               due,
  output fe_op_e             s_op,
  output logic [ADDR_W-1:0]  s_addr,
  output logic [DATA_W-1:0]  s_wdata,
  output fe_tag_t            s_tag,
  output logic [ID_W-1:0]    s_id,
  output logic               s_hopped,
  output logic [RETRY_W-1:0] s_cnt
);
  localparam int GAP_W = (RETRY_GAP > 1) ? $clog2(RETRY_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_RELOAD = GAP_W'(RETRY_GAP - 1);

  fe_slot_e          st_q, st_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              cap;
  logic [ADDR_W-1:0] addr_d;
  logic              hop_d;
  logic [RETRY_W-1:0] cnt_d;

  always_comb begin
    st_d  = st_q;
    gap_d = gap_q;
    cap   = 1'b0;
    if (att_valid && (att_from_slot || att_kind != K_DONE)) begin
      cap = (att_kind != K_DONE);
      case (att_kind)
        K_FWD:   st_d = S_HOP;
        K_PARK: begin
          st_d  = S_WAIT;
          gap_d = GAP_RELOAD;
        end
        default: st_d = S_IDLE;
      endcase
    end else if (st_q == S_WAIT && gap_q != '0) begin
      gap_d = gap_q - 1'b1;
    end
    addr_d = (att_kind == K_FWD) ? fwd_addr : att_addr;
    hop_d  = att_hopped || (att_kind == K_FWD);
    cnt_d  = (att_kind == K_PARK) ? att_cnt + 1'b1 : att_cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      gap_q <= '0;
    end else begin
      st_q  <= st_d;
      gap_q <= gap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      s_op     <= att_op;
      s_addr   <= addr_d;
      s_wdata  <= att_wdata;
      s_tag    <= att_tag;
      s_id     <= att_id;
      s_hopped <= hop_d;
      s_cnt    <= cnt_d;
    end
  end

  assign st  = st_q;
  assign due = (gap_q == '0);
endmodule

// File: rtl/fe_sync_mem_ctrl.sv
`timescale 1ns/1ps
module fe_sync_mem_ctrl
  import fe_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int RETRY_W   = 10,
  parameter int RETRY_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [3:0]        req_tag,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  output logic [ID_W-1:0]   rsp_id,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_data
);
  fe_slot_e           slot_st;
  logic [1:0]         slot_state;
  logic               slot_due;
  fe_op_e             s_op;
  logic [ADDR_W-1:0]  s_addr;
  logic [DATA_W-1:0]  s_wdata;
  fe_tag_t            s_tag;
  logic [ID_W-1:0]    s_id;
  logic               s_hopped;
  logic [RETRY_W-1:0] s_cnt;

  logic               use_slot;
  fe_op_e             att_op;
  logic [ADDR_W-1:0]  att_addr;
  logic [DATA_W-1:0]  att_wdata;
  fe_tag_t            att_tag;
  logic [ID_W-1:0]    att_id;
  logic               att_hopped;
  logic [RETRY_W-1:0] att_cnt;
  logic               att_valid;

  logic [DATA_W-1:0]  rd_data;
  fe_tag_t            rd_tag;
  fe_kind_e           ev_kind;
  fe_st_e             ev_status;
  logic [DATA_W-1:0]  ev_data;
  logic               ev_we;
  logic [DATA_W-1:0]  ev_wr_data;
  fe_tag_t            ev_wr_tag;
  logic [ADDR_W-1:0]  ev_fwd_addr;
  logic               rsp_done;

  logic               rsp_valid_q;
  logic [ID_W-1:0]    rsp_id_q;
  fe_st_e             rsp_st_q;
  logic [DATA_W-1:0]  rsp_data_q;

  assign slot_state = slot_st;
  // The slot takes the engine when it holds a hop or a due retry.
  assign use_slot = (slot_state == S_HOP) || (slot_state == S_WAIT && slot_due);

  always_comb begin
    if (use_slot) begin
      att_op     = s_op;
      att_addr   = s_addr;
      att_wdata  = s_wdata;
      att_tag    = s_tag;
      att_id     = s_id;
      att_hopped = s_hopped;
      att_cnt    = s_cnt;
    end else begin
      att_op     = fe_op_e'(req_op);
      att_addr   = req_addr;
      att_wdata  = req_wdata;
      att_tag    = fe_tag_t'(req_tag);
      att_id     = req_id;
      att_hopped = 1'b0;
      att_cnt    = '0;
    end
  end

  // An outside request that would need the slot waits while it is taken.
  assign req_ready = !use_slot && !(slot_state != S_IDLE && ev_kind != K_DONE);
  assign att_valid = use_slot || (req_valid && req_ready);
  assign rsp_done  = att_valid && (ev_kind == K_DONE);

  fe_tag_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (att_addr),
    .rd_data (rd_data),
    .rd_tag  (rd_tag),
    .we      (ev_we && att_valid),
    .wr_addr (att_addr),
    .wr_data (ev_wr_data),
    .wr_tag  (ev_wr_tag)
  );

  fe_access_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RETRY_W(RETRY_W)) u_eval (
    .op       (att_op),
    .wdata    (att_wdata),
    .tag_in   (att_tag),
    .rd_data  (rd_data),
    .rd_tag   (rd_tag),
    .hopped   (att_hopped),
    .cnt      (att_cnt),
    .kind     (ev_kind),
    .status   (ev_status),
    .rsp_data (ev_data),
    .we       (ev_we),
    .wr_data  (ev_wr_data),
    .wr_tag   (ev_wr_tag),
    .fwd_addr (ev_fwd_addr)
  );

  fe_wait_slot #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
    .RETRY_W(RETRY_W), .RETRY_GAP(RETRY_GAP)
  ) u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .att_valid     (att_valid),
    .att_from_slot (use_slot),
    .att_kind      (ev_kind),
    .att_op        (att_op),
    .att_addr      (att_addr),
    .fwd_addr      (ev_fwd_addr),
    .att_wdata     (att_wdata),
    .att_tag       (att_tag),
    .att_id        (att_id),
    .att_hopped    (att_hopped),
    .att_cnt       (att_cnt),
    .st            (slot_st),
    .due           (slot_due),
    .s_op          (s_op),
    .s_addr        (s_addr),
    .s_wdata       (s_wdata),
    .s_tag         (s_tag),
    .s_id          (s_id),
    .s_hopped      (s_hopped),
    .s_cnt         (s_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= rsp_done;
  end

  always_ff @(posedge clk) begin
    if (rsp_done) begin
      rsp_id_q   <= att_id;
      rsp_st_q   <= ev_status;
      rsp_data_q <= ev_data;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_id     = rsp_id_q;
  assign rsp_status = rsp_st_q;
  assign rsp_data   = rsp_data_q;
endmodule

// File: rtl/fe_sync_mem_chk.sv
`timescale 1ns/1ps
module fe_sync_mem_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [DATA_W-1:0] rsp_data,
  input logic [1:0]        slot_state
);
  // R1: nothing answers and the slot stays empty while reset is held.
  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r1: assert (!rsp_valid && slot_state == 2'd0);
  end

  p_tagset_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op == 3'd6 |=> rsp_valid && rsp_status == 2'd0);

  // R8 and R11: both trap statuses carry zero data.
  p_trap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_status == 2'd1 || rsp_status == 2'd2) |-> rsp_data == '0);

  p_accept_progress_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || slot_state != 2'd0);

  p_hop_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    slot_state == 2'd1 |=> slot_state != 2'd1);

  p_hop_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
    slot_state == 2'd1 |-> !req_ready);
endmodule

bind fe_sync_mem_ctrl fe_sync_mem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_data   (rsp_data),
  .slot_state (slot_state)
);

// File: tb/tb_fe_sync_mem_ctrl.sv
`timescale 1ns/1ps
module tb_fe_sync_mem_ctrl;
  localparam int AW = 4, DW = 16, IW = 4, RW = 3, GAP = 2;
  localparam int EXH = GAP * ((1 << RW) - 1);
  localparam int NV = 33;

  logic clk, rst_n, req_valid, req_ready, rsp_valid;
  logic [2:0] req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_data;
  logic [3:0] req_tag;
  logic [IW-1:0] req_id, rsp_id;
  logic [1:0] rsp_status;

  fe_sync_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .RETRY_W(RW), .RETRY_GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .req_id(req_id), .rsp_valid(rsp_valid), .rsp_id(rsp_id),
    .rsp_status(rsp_status), .rsp_data(rsp_data));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, errs = 0;
  logic got [16];
  logic [1:0] gst [16];
  logic [DW-1:0] gdt [16];
  int gcyc [16];

  always @(negedge clk) begin
    if (rsp_valid) begin
      got[rsp_id]  = 1'b1;
      gst[rsp_id]  = rsp_status;
      gdt[rsp_id]  = rsp_data;
      gcyc[rsp_id] = cyc;
    end
  end

  // {req, op, addr, wdata, tag, status, no-data-check, data}
  localparam logic [49:0] VEC [NV] = '{
    {4'd1, 3'd3, 4'h0, 16'h0000, 4'b0000, 2'd1, 1'b0, 16'h0000}, // R1 fresh word is empty
    {4'd2, 3'd6, 4'h1, 16'h1234, 4'b0001, 2'd0, 1'b1, 16'h0000}, // R2
    {4'd3, 3'd0, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h1234}, // R3 load
    {4'd4, 3'd2, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h1234}, // R4
    {4'd4, 3'd2, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h1234}, // R4 still full
    {4'd5, 3'd3, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h1234}, // R5
    {4'd6, 3'd4, 4'h1, 16'h00AB, 4'b0000, 2'd0, 1'b0, 16'h0000}, // R6 word was emptied
    {4'd6, 3'd2, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h00AB}, // R6
    {4'd3, 3'd1, 4'h1, 16'h5555, 4'b0000, 2'd0, 1'b0, 16'h0000}, // R3 store
    {4'd3, 3'd3, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h5555}, // R3 full kept
    {4'd3, 3'd1, 4'h1, 16'h6666, 4'b0000, 2'd0, 1'b0, 16'h0000}, // R3
    {4'd3, 3'd4, 4'h1, 16'h0101, 4'b0000, 2'd0, 1'b0, 16'h0000}, // R3 empty kept
    {4'd7, 3'd5, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h0000}, // R7
    {4'd7, 3'd2, 4'h1, 16'h0000, 4'b0000, 2'd1, 1'b0, 16'h0000}, // R7 now empty
    {4'd7, 3'd0, 4'h1, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h0101}, // R7 data kept
    {4'd2, 3'd6, 4'h3, 16'h0002, 4'b0010, 2'd0, 1'b1, 16'h0000}, // R2 a3 -> a2
    {4'd10, 3'd4, 4'h3, 16'h7777, 4'b0000, 2'd0, 1'b0, 16'h0000}, // R10
    {4'd10, 3'd0, 4'h2, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h7777}, // R10
    {4'd10, 3'd0, 4'h3, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h7777}, // R10
    {4'd2, 3'd6, 4'h4, 16'h0003, 4'b0010, 2'd0, 1'b1, 16'h0000}, // R2 a4 -> a3
    {4'd10, 3'd0, 4'h4, 16'h0000, 4'b0000, 2'd3, 1'b0, 16'h0002}, // R10 second hop
    {4'd2, 3'd6, 4'h9, 16'h4242, 4'b0001, 2'd0, 1'b1, 16'h0000}, // R2
    {4'd2, 3'd6, 4'h5, 16'h0009, 4'b0110, 2'd0, 1'b1, 16'h0000}, // R2 trap+fwd
    {4'd11, 3'd2, 4'h5, 16'h0000, 4'b0000, 2'd2, 1'b0, 16'h0000}, // R11
    {4'd11, 3'd4, 4'h5, 16'h1111, 4'b0000, 2'd2, 1'b0, 16'h0000}, // R11
    {4'd11, 3'd0, 4'h5, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h4242}, // R11 plain forwarded
    {4'd2, 3'd6, 4'h6, 16'hABCD, 4'b1001, 2'd0, 1'b1, 16'h0000}, // R2 poison
    {4'd12, 3'd0, 4'h6, 16'h0000, 4'b0000, 2'd2, 1'b0, 16'h0000}, // R12
    {4'd12, 3'd1, 4'h6, 16'h0000, 4'b0000, 2'd2, 1'b0, 16'h0000}, // R12
    {4'd12, 3'd5, 4'h6, 16'h0000, 4'b0000, 2'd2, 1'b0, 16'h0000}, // R12
    {4'd12, 3'd6, 4'h6, 16'h0000, 4'b0001, 2'd0, 1'b0, 16'hABCD}, // R12 data untouched
    {4'd8, 3'd4, 4'h9, 16'h2222, 4'b0000, 2'd1, 1'b0, 16'h0000}, // R8 word full
    {4'd8, 3'd0, 4'h9, 16'h0000, 4'b0000, 2'd0, 1'b0, 16'h4242}  // R8 unchanged
  };

  task automatic chk(input int rn, input bit ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", rn, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [3:0] t, input logic [IW-1:0] id, output int acc);
    @(negedge clk);
    got[id] = 1'b0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_tag = t; req_id = id;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    acc = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input logic [IW-1:0] id);
    for (int n = 0; n < 3000 && !got[id]; n++) @(negedge clk);
    chk(13, got[id], "response missing", 32'(got[id]), 32'd1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int acc, acc2;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
    req_wdata = '0; req_tag = '0; req_id = '0;
    for (int i = 0; i < 16; i++) got[i] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(1, req_ready === 1'b1, "ready in reset", 32'(req_ready), 32'd1);   // R1
    chk(1, rsp_valid === 1'b0, "rsp in reset", 32'(rsp_valid), 32'd0);     // R1
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      send(v[45:43], v[42:39], v[38:23], v[22:19], IW'(i), acc);
      wait_rsp(IW'(i));
      chk(int'(v[49:46]), gst[IW'(i)] === v[18:17], $sformatf("vector %0d status", i),
          32'(gst[IW'(i)]), 32'(v[18:17]));
      chk(13, got[IW'(i)], $sformatf("vector %0d id", i), 32'(got[IW'(i)]), 32'd1);
      if (!v[16])
        chk(int'(v[49:46]), gdt[IW'(i)] === v[15:0], $sformatf("vector %0d data", i),
            32'(gdt[IW'(i)]), 32'(v[15:0]));
    end

    // R8: exhaustion lands exactly EXH edges after acceptance.
    send(3'd2, 4'hA, 16'h0, 4'h0, 4'd5, acc);
    wait_rsp(4'd5);
    chk(8, gst[5] == 2'd1, "exhaust status", 32'(gst[5]), 32'd1);
    chk(8, gcyc[5] - acc == EXH, "exhaust timing", 32'(gcyc[5] - acc), 32'(EXH));

    // R9: a parked consumer is released by a later producer.
    send(3'd3, 4'h7, 16'h0, 4'h0, 4'd1, acc);
    send(3'd4, 4'h7, 16'h0C0C, 4'h0, 4'd2, acc2);
    wait_rsp(4'd2);
    wait_rsp(4'd1);
    chk(9, gst[2] == 2'd0, "producer status", 32'(gst[2]), 32'd0);
    chk(9, gst[1] == 2'd0, "consumer status", 32'(gst[1]), 32'd0);
    chk(9, gdt[1] == 16'h0C0C, "consumer data", 32'(gdt[1]), 32'h0C0C);
    chk(13, gcyc[2] < gcyc[1], "later id answered first", 32'(gcyc[2]), 32'(gcyc[1]));
    send(3'd2, 4'h7, 16'h0, 4'h0, 4'd3, acc);
    wait_rsp(4'd3);
    chk(9, gst[3] == 2'd1, "consumer emptied word", 32'(gst[3]), 32'd1);

    // R13: a second waiter is held off until the slot frees.
    send(3'd2, 4'h8, 16'h0, 4'h0, 4'd6, acc);
    send(3'd2, 4'h8, 16'h0, 4'h0, 4'd7, acc2);
    wait_rsp(4'd6);
    wait_rsp(4'd7);
    chk(13, acc2 > gcyc[6] - 1, "second waiter held", 32'(acc2), 32'(gcyc[6]));
    chk(13, gst[7] == 2'd1 && gst[6] == 2'd1, "both exhaust", 32'(gst[7]), 32'd1);

    report();
  end
endmodule